// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare channel that sits beside an 8-bit timer counter. The counter, its prescaler and the register decode live outside; the channel sees the live count, a strobe saying the count has just taken a new value, and a run indication.

In capture mode the channel brings an external pin into the clock domain through a two-flop synchronizer and watches the synchronized level for a selected edge. On a qualifying edge it stores the count from that cycle. In compare mode it holds a software-written compare value in a shadow register. That value becomes active only when the counter reaches zero. When the active value matches an updated count, the channel sets, clears or toggles its output pin.

Every capture or compare event sets a sticky interrupt flag and emits a one-cycle DMA trigger. The interrupt line is the flag gated by a mask. All pins are plain level or strobe signals. No stream crosses the boundary, so there is no valid/ready handshake. A write to the compare value is always accepted. A second write before the zero point replaces the pending value.

Top module: `tcc_channel`

## Requirements
- R1: After reset, `cmp_out`, `irq_flag`, `irq` and `dma_trig` are 0, and `chan_val` reads 0x00.
- R2: Capture triggers only while `cfg_capture`=1 and `cnt_run`=1. The edge is chosen by `cap_edge`: 0 none, 1 rising, 2 falling, 3 either.
- R3: The pin passes through two synchronizing flops and then an edge detector. If the pin changes before clock edge k, the captured register takes the `cnt_val` present just before edge k+2. The register is visible after that edge.
- R4: In compare mode, a match of `cnt_val` with the active compare value acts on `cmp_out` according to `cmp_mode`: 0 sets it to 1, 1 clears it to 0, 2 toggles it.
- R5: With `cmp_mode`=3, a match sets `cmp_out` and a counter update to 0x00 clears it. With `cmp_mode`=4, a match clears `cmp_out` and an update to 0x00 sets it. A match wins over the zero action.
- R6: A compare match counts only in cycles where `cnt_upd`=1. The output and the events stay unchanged while `cnt_upd`=0, even if the count equals the compare value.
- R7: A value written on `cmp_wr` takes effect at the next cycle with `cnt_upd`=1 and `cnt_val`=0x00. That zero cycle already compares against the new value. Before that cycle the old value stays in force.
- R8: A `timer_clr` pulse returns `cmp_out` to its mode's initial level: 1 for modes 1 and 4, 0 otherwise. While `cmp_mode`=7, `cmp_out` is held at 0.
- R9: Each event sets `irq_flag`, which stays set until a `flag_clr` pulse. When an event and `flag_clr` arrive in the same cycle, the flag stays set.
- R10: `irq` is high exactly when `irq_flag` and `irq_mask` are both 1.
- R11: Each event drives `dma_trig` high for one cycle, in the same cycle that the flag first shows it.
- R12: `chan_val` shows the captured count while `cfg_capture`=1. Otherwise it shows the last written compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | 8 | Current counter value |
| cnt_upd | input | 1 | Counter took a new value this cycle |
| cnt_run | input | 1 | Timer is running |
| cfg_capture | input | 1 | 1 selects capture mode, 0 selects compare mode |
| cap_edge | input | 2 | Capture edge select |
| cmp_mode | input | 3 | Compare output action |
| cap_pin | input | 1 | Asynchronous capture input pin |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wr_data | input | 8 | Compare value to write |
| timer_clr | input | 1 | Timer clear pulse; reinitializes the output |
| flag_clr | input | 1 | Clears the interrupt flag |
| irq_mask | input | 1 | Interrupt enable for this channel |
| cmp_out | output | 1 | Compare output pin |
| chan_val | output | 8 | Channel register readback |
| irq_flag | output | 1 | Sticky event flag |
| irq | output | 1 | Masked interrupt request |
| dma_trig | output | 1 | One-cycle DMA trigger per event |

## Verification
A wrong active compare value shows up as a misplaced output transition and a misplaced DMA pulse, one edge after the count that should or should not have matched. A stale shadow would be missed until the next zero crossing, so the tests cross zero on purpose. A synchronizer that is off by one stage shifts the captured count by one, and this shows in `chan_val` right after the capturing edge. A flag that fails to hold, or a trigger that lasts two cycles, shows up within one cycle of the event.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  typedef enum logic [2:0] {
    CM_SET   = 3'd0,
    CM_CLR   = 3'd1,
    CM_TGL   = 3'd2,
    CM_SET_Z = 3'd3,
    CM_CLR_Z = 3'd4,
    CM_RSV5  = 3'd5,
    CM_RSV6  = 3'd6,
    CM_INIT  = 3'd7
  } cmp_mode_e;

  // Level the output takes on a timer clear, per mode.
  function automatic logic init_level(cmp_mode_e m);
    return (m == CM_CLR) || (m == CM_CLR_Z);
  endfunction

endpackage

// File: rtl/tcc_sync_edge.sv
module tcc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop.
  localparam int LAST = STAGES;

  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LAST-1:0], pin};
  end

  assign rise =  chain[LAST-1] & ~chain[LAST];
  assign fall = ~chain[LAST-1] &  chain[LAST];
endmodule

// File: rtl/tcc_cmp_shadow.sv
module tcc_cmp_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         at_zero,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic [W-1:0] cmp_eff
);
  logic pending;
  logic load;

  assign load    = pending & at_zero;
  assign cmp_eff = load ? shadow : active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow  <= '0;
      active  <= '0;
      pending <= 1'b0;
    end else begin
      if (load) active <= shadow;
      if (wr_en) begin
        shadow  <= wr_data;
        pending <= 1'b1;
      end else if (load) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tcc_out_ctl.sv
module tcc_out_ctl
  import tcc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cmp_mode_e mode,
  input  logic      en,
  input  logic      hit,
  input  logic      at_zero,
  input  logic      clr,
  output logic      out
);
  logic nxt;

  always_comb begin
    nxt = out;
    if (clr) begin
      nxt = init_level(mode);
    end else if (mode == CM_INIT) begin
      nxt = 1'b0;
    end else if (en) begin
      unique case (mode)
        CM_SET:   if (hit) nxt = 1'b1;
        CM_CLR:   if (hit) nxt = 1'b0;
        CM_TGL:   if (hit) nxt = ~out;
        CM_SET_Z: if (hit) nxt = 1'b1; else if (at_zero) nxt = 1'b0;
        CM_CLR_Z: if (hit) nxt = 1'b0; else if (at_zero) nxt = 1'b1;
        default:  nxt = out;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out <= 1'b0;
    else        out <= nxt;
  end
endmodule

// File: rtl/tcc_evt.sv
module tcc_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic flag_clr,
  input  logic mask,
  output logic flag,
  output logic irq,
  output logic dma
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      dma  <= 1'b0;
    end else begin
      flag <= event_i | (flag & ~flag_clr);
      dma  <= event_i;
    end
  end

  assign irq = flag & mask;
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_upd,
  input  logic             cnt_run,
  input  logic             cfg_capture,
  input  logic [1:0]       cap_edge,
  input  logic [2:0]       cmp_mode,
  input  logic             cap_pin,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wr_data,
  input  logic             timer_clr,
  input  logic             flag_clr,
  input  logic             irq_mask,
  output logic             cmp_out,
  output logic [CNT_W-1:0] chan_val,
  output logic             irq_flag,
  output logic             irq,
  output logic             dma_trig
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  edge_sel_e        esel;
  cmp_mode_e        cmode;
  logic             pin_rise, pin_fall, edge_ok;
  logic             cap_ev, hit, at_zero, any_ev;
  logic [CNT_W-1:0] cap_reg, shadow, cmp_act, cmp_eff;

  assign esel  = edge_sel_e'(cap_edge);
  assign cmode = cmp_mode_e'(cmp_mode);

  tcc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise(pin_rise), .fall(pin_fall)
  );

  always_comb begin
    unique case (esel)
      EDGE_RISE: edge_ok = pin_rise;
      EDGE_FALL: edge_ok = pin_fall;
      EDGE_ANY:  edge_ok = pin_rise | pin_fall;
      default:   edge_ok = 1'b0;
    endcase
  end

  assign cap_ev  = cfg_capture & cnt_run & edge_ok;
  assign at_zero = cnt_upd & (cnt_val == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_reg <= '0;
    else if (cap_ev) cap_reg <= cnt_val;
  end

  tcc_cmp_shadow #(.W(CNT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(cmp_wr), .wr_data(cmp_wr_data),
    .at_zero(at_zero), .shadow(shadow), .active(cmp_act), .cmp_eff(cmp_eff)
  );

  assign hit = ~cfg_capture & cnt_upd & (cnt_val == cmp_eff);

  tcc_out_ctl u_out (
    .clk(clk), .rst_n(rst_n), .mode(cmode), .en(~cfg_capture),
    .hit(hit), .at_zero(at_zero), .clr(timer_clr), .out(cmp_out)
  );

  assign any_ev = hit | cap_ev;

  tcc_evt u_evt (
    .clk(clk), .rst_n(rst_n), .event_i(any_ev), .flag_clr(flag_clr),
    .mask(irq_mask), .flag(irq_flag), .irq(irq), .dma(dma_trig)
  );

  assign chan_val = cfg_capture ? cap_reg : shadow;
endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic             cnt_upd,
  input logic             cfg_capture,
  input logic [2:0]       cmp_mode,
  input logic             timer_clr,
  input logic             flag_clr,
  input logic             irq_mask,
  input logic             cmp_out,
  input logic             irq_flag,
  input logic             irq,
  input logic             dma_trig,
  input logic [CNT_W-1:0] cap_reg,
  input logic [CNT_W-1:0] cmp_act,
  input logic             hit,
  input logic             at_zero
);
  // R11: the trigger and the flag appear together
  assert_dma_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_trig |-> irq_flag);

  // R10: masked channel never requests
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !irq);

  // R9: flag holds until cleared
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);

  // R3: a capture trigger carries the count of the detecting cycle
  assert_cap_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_trig && $past(cfg_capture)) |-> (cap_reg == $past(cnt_val)));

  // R4: output moves only on a match, a zero, a clear or mode 7
  assert_out_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_clr && cmp_mode != 3'd7 && !hit && !at_zero) |=> $stable(cmp_out));

  // R7: active compare value changes only at a counter zero
  assert_cmp_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !at_zero |=> $stable(cmp_act));

  // R6: compare events need a counter update
  assert_upd_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_trig |-> ($past(cnt_upd) || $past(cfg_capture)));
endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_upd(cnt_upd),
  .cfg_capture(cfg_capture), .cmp_mode(cmp_mode), .timer_clr(timer_clr),
  .flag_clr(flag_clr), .irq_mask(irq_mask), .cmp_out(cmp_out),
  .irq_flag(irq_flag), .irq(irq), .dma_trig(dma_trig), .cap_reg(cap_reg),
  .cmp_act(cmp_act), .hit(hit), .at_zero(at_zero)
);

// File: tb/tcc_channel_tb_top.sv
module tcc_channel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cnt_val;
  logic       cnt_upd, cnt_run, cfg_capture;
  logic [1:0] cap_edge;
  logic [2:0] cmp_mode;
  logic       cap_pin, cmp_wr;
  logic [7:0] cmp_wr_data;
  logic       timer_clr, flag_clr, irq_mask;
  logic       cmp_out, irq_flag, irq, dma_trig;
  logic [7:0] chan_val;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tcc_channel dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_upd(cnt_upd),
    .cnt_run(cnt_run), .cfg_capture(cfg_capture), .cap_edge(cap_edge),
    .cmp_mode(cmp_mode), .cap_pin(cap_pin), .cmp_wr(cmp_wr),
    .cmp_wr_data(cmp_wr_data), .timer_clr(timer_clr), .flag_clr(flag_clr),
    .irq_mask(irq_mask), .cmp_out(cmp_out), .chan_val(chan_val),
    .irq_flag(irq_flag), .irq(irq), .dma_trig(dma_trig)
  );

  // {mode[2:0], count[7:0], expected cmp_out}; active compare value is 5
  localparam logic [11:0] VEC [14] = '{
    {3'd0, 8'h00, 1'b0}, {3'd0, 8'h05, 1'b1}, {3'd0, 8'h06, 1'b1},
    {3'd1, 8'h05, 1'b0}, {3'd2, 8'h05, 1'b1}, {3'd2, 8'h04, 1'b1},
    {3'd2, 8'h05, 1'b0}, {3'd3, 8'h05, 1'b1}, {3'd3, 8'h00, 1'b0},
    {3'd3, 8'h05, 1'b1}, {3'd4, 8'h05, 1'b0}, {3'd4, 8'h00, 1'b1},
    {3'd4, 8'h03, 1'b1}, {3'd4, 8'h05, 1'b0}
  };

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Pin change, then three edges with the count stepping base, base+1, base+2.
  task automatic cap_seq(logic level, logic [7:0] base);
    cap_pin = level; cnt_val = base;
    cyc(); cnt_val = base + 8'd1;
    cyc(); cnt_val = base + 8'd2;
    cyc();
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int dcount;
    logic o0;
    rst_n = 1'b0; cnt_val = '0; cnt_upd = 1'b0; cnt_run = 1'b0;
    cfg_capture = 1'b0; cap_edge = 2'd0; cmp_mode = 3'd0; cap_pin = 1'b0;
    cmp_wr = 1'b0; cmp_wr_data = '0; timer_clr = 1'b0; flag_clr = 1'b0;
    irq_mask = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 cmp_out", cmp_out, 0);
    chk("R1 irq_flag", irq_flag, 0);
    chk("R1 dma_trig", dma_trig, 0);
    chk("R1 chan_val", chan_val, 0);
    chk("R1 irq", irq, 0);

    // Write compare 5, pending until zero
    cmp_wr = 1'b1; cmp_wr_data = 8'h05; cyc(); cmp_wr = 1'b0;
    chk("R12 chan_val shows written compare", chan_val, 8'h05);
    timer_clr = 1'b1; cyc(); timer_clr = 1'b0;

    // Table walk: R4 modes 0..2, R5 modes 3/4, R7 load at zero
    cnt_upd = 1'b1;
    foreach (VEC[i]) begin
      cmp_mode = VEC[i][11:9];
      cnt_val  = VEC[i][8:1];
      cyc();
      chk($sformatf("R4/R5 vector %0d cmp_out", i), cmp_out, VEC[i][0]);
    end
    cnt_upd = 1'b0;
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;

    // R6: no action without counter update
    cmp_mode = 3'd2; cnt_val = 8'h05;
    o0 = cmp_out;
    dcount = 0;
    for (int k = 0; k < 3; k++) begin cyc(); dcount += dma_trig; end
    chk("R6 no event while cnt_upd low", dcount, 0);
    chk("R6 output stable while cnt_upd low", cmp_out, o0);
    cnt_upd = 1'b1; cyc(); cnt_upd = 1'b0;
    chk("R6 toggle on update", cmp_out, !o0);
    chk("R11 dma pulse high", dma_trig, 1);
    cyc();
    chk("R11 dma pulse one cycle", dma_trig, 0);
    chk("R6 held after single update", cmp_out, !o0);

    // R7: new compare 9 waits for zero
    cmp_wr = 1'b1; cmp_wr_data = 8'h09; cyc(); cmp_wr = 1'b0;
    o0 = cmp_out;
    cnt_upd = 1'b1;
    cnt_val = 8'h05; cyc();
    chk("R7 old value still matches", cmp_out, !o0);
    cnt_val = 8'h09; cyc();
    chk("R7 new value not yet active", cmp_out, !o0);
    cnt_val = 8'h00; cyc();
    cnt_val = 8'h09; cyc();
    chk("R7 new value active after zero", cmp_out, o0);
    cnt_upd = 1'b0;

    // R8: timer clear initial levels, mode 7 hold
    cmp_mode = 3'd1; timer_clr = 1'b1; cyc();
    chk("R8 clear mode 1", cmp_out, 1);
    cmp_mode = 3'd4; cyc();
    chk("R8 clear mode 4", cmp_out, 1);
    cmp_mode = 3'd0; cyc();
    chk("R8 clear mode 0", cmp_out, 0);
    cmp_mode = 3'd1; cyc(); timer_clr = 1'b0;
    cmp_mode = 3'd7; cyc();
    chk("R8 mode 7 forces 0", cmp_out, 0);
    cmp_mode = 3'd0;

    // R9/R10/R11 flag, mask, trigger
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    chk("R9 flag cleared", irq_flag, 0);
    cnt_val = 8'h09; cnt_upd = 1'b1; cyc(); cnt_upd = 1'b0;
    chk("R9 flag set by event", irq_flag, 1);
    chk("R10 irq masked", irq, 0);
    chk("R11 dma with flag", dma_trig, 1);
    irq_mask = 1'b1; cyc();
    chk("R9 flag sticky", irq_flag, 1);
    chk("R10 irq unmasked", irq, 1);
    flag_clr = 1'b1; cnt_upd = 1'b1; cyc(); cnt_upd = 1'b0; flag_clr = 1'b0;
    chk("R9 set wins over clear", irq_flag, 1);
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    chk("R9 flag cleared again", irq_flag, 0);
    chk("R10 irq drops", irq, 0);

    // Capture: R2, R3, R12
    cfg_capture = 1'b1; cnt_run = 1'b1; cap_edge = 2'd1;
    cyc();
    chk("R12 chan_val shows capture register", chan_val, 8'h00);
    cap_seq(1'b1, 8'h30);
    chk("R3 rising capture value", chan_val, 8'h32);
    chk("R3 capture trigger", dma_trig, 1);
    cyc();
    chk("R11 capture trigger one cycle", dma_trig, 0);
    cap_pin = 1'b0; cnt_val = 8'h40; dcount = 0;
    for (int k = 0; k < 4; k++) begin cyc(); dcount += dma_trig; end
    chk("R2 falling ignored in rising mode", dcount, 0);
    chk("R2 register kept", chan_val, 8'h32);
    cap_edge = 2'd2;
    cap_pin = 1'b1; dcount = 0;
    for (int k = 0; k < 4; k++) begin cyc(); dcount += dma_trig; end
    chk("R2 rising ignored in falling mode", dcount, 0);
    cap_seq(1'b0, 8'h50);
    chk("R2 falling capture", chan_val, 8'h52);
    cyc();
    cap_edge = 2'd3;
    cap_seq(1'b1, 8'h60);
    chk("R2 either edge rise", chan_val, 8'h62);
    cyc();
    cap_seq(1'b0, 8'h70);
    chk("R2 either edge fall", chan_val, 8'h72);
    cyc();
    cap_edge = 2'd0; dcount = 0;
    cap_pin = 1'b1;
    for (int k = 0; k < 4; k++) begin cyc(); dcount += dma_trig; end
    chk("R2 edge none ignores pin", dcount, 0);
    cap_edge = 2'd1; cnt_run = 1'b0; cap_pin = 1'b0; cyc(); cyc(); cyc();
    cap_pin = 1'b1; dcount = 0;
    for (int k = 0; k < 4; k++) begin cyc(); dcount += dma_trig; end
    chk("R2 stopped timer ignores pin", dcount, 0);
    chk("R2 register unchanged when stopped", chan_val, 8'h72);
    cfg_capture = 1'b0; cyc();
    chk("R12 compare readback returns", chan_val, 8'h09);

    report();
  end
endmodule